// File: doc/BRIEF.md
# Three-Bank Cascaded Interrupt Controller

This block gathers level-sensitive interrupt lines from three groups: eight basic sources and two peripheral banks of thirty-two sources each. Each group has its own enable mask. A source is pending when its raw line is high and its enable bit is set. The first group, called the basic bank, also has a summary word. This word holds the eight masked basic sources, one cascade flag for each peripheral bank, and eleven shortcut bits. The shortcut bits copy selected peripheral sources directly, so a handler can service them without reading the bank status. The single interrupt output is the OR of the whole summary word.

A separate fast-interrupt selector routes one source, picked by index, straight to a second output. This path ignores the enable masks. Software uses a 32-bit read/write register port to reach the block. Enable registers are write-one-to-set and disable registers are write-one-to-clear, so no read-modify-write is needed.

Top module: `irqc_top`

## Requirements
- R1: Reading offset 0x04 returns bank-1 raw lines AND the bank-1 enable mask. Reading offset 0x08 returns the same for bank 2.
- R2: Bits 7:0 of the summary word, read at offset 0x00, are the basic raw lines AND the basic enable mask.
- R3: Summary bit 8 is 1 exactly when some bank-1 source that is not a shortcut is pending. Bit 9 is the same for bank 2. A pending shortcut source never sets these bits.
- R4: Summary bits 10 to 14 show the pending state of bank-1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 show bank-2 sources 21, 22, 23, 24, 25 and 30, in that order. Bits 31 to 21 read as zero.
- R5: irq_out is the OR of summary bits 20:0. The basic enable mask can neither mask the cascade flags nor mask the shortcut bits.
- R6: Writing offset 0x18, 0x10 or 0x14 sets the basic, bank-1 or bank-2 enable bits where the data is 1. Reading the same offset returns the mask. The basic mask keeps only data bits 7:0, and data bits 8 and up have no effect.
- R7: Writing offset 0x24, 0x1c or 0x20 clears the basic, bank-1 or bank-2 enable bits where the data is 1. Reading these offsets, or any unmapped offset, returns zero.
- R8: Writing offset 0x0c stores data bits 7:0 as the fast-interrupt control. Bits 6:0 are the index and bit 7 is the enable. A read returns the stored byte.
- R9: When control bit 7 is set, fiq_out is the raw line of the selected source, regardless of enable masks. Index 0 to 31 selects bank 1, 32 to 63 selects bank 2, and 64 to 71 selects the basic sources. An index above 71 gives 0, and a clear bit 7 gives 0.
- R10: Reset clears all three enable masks and the fast-interrupt control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_basic | input | 8 | Basic source lines |
| src_bank1 | input | 32 | Bank-1 source lines |
| src_bank2 | input | 32 | Bank-2 source lines |
| irq_out | output | 1 | Interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Several properties are checked on every cycle:
- set and clear arithmetic of each enable mask, and the mask holding still when no write hits it;
- the control byte capture;
- a non-shortcut pending source always raising irq_out;
- a shortcut-only bank never raising its cascade flag;
- a disabled or out-of-range selector never driving fiq_out.

The exact bit positions of the shortcuts, the fast-interrupt index order across the three banks, and the read-back of every offset are shown only by the bench scenarios. The bench compares these against its behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BASIC_N  = 8;
  localparam int BANK_N   = 32;
  localparam int SC1_N    = 5;
  localparam int SC2_N    = 6;
  localparam int SUM1_BIT = BASIC_N;
  localparam int SUM2_BIT = BASIC_N + 1;
  localparam int SC1_BASE = BASIC_N + 2;
  localparam int SC2_BASE = SC1_BASE + SC1_N;
  localparam int WORD_N   = SC2_BASE + SC2_N;
  localparam int IDX_W    = 7;
  localparam int CTL_W    = IDX_W + 1;

  // Offsets (behavioural: fixed by the register layout)
  localparam logic [5:0] A_STAT0 = 6'h00;
  localparam logic [5:0] A_STAT1 = 6'h04;
  localparam logic [5:0] A_STAT2 = 6'h08;
  localparam logic [5:0] A_FCTL  = 6'h0c;
  localparam logic [5:0] A_SET1  = 6'h10;
  localparam logic [5:0] A_SET2  = 6'h14;
  localparam logic [5:0] A_SET0  = 6'h18;
  localparam logic [5:0] A_CLR1  = 6'h1c;
  localparam logic [5:0] A_CLR2  = 6'h20;
  localparam logic [5:0] A_CLR0  = 6'h24;

  // Bank-1 source number carried by shortcut slot k
  function automatic int sc1_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  // Bank-2 source number carried by shortcut slot k
  function automatic int sc2_src(input int k);
    return (k < 5) ? 21 + k : 30;
  endfunction

  function automatic logic [BANK_N-1:0] sc1_mask();
    logic [BANK_N-1:0] m = '0;
    for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BANK_N-1:0] sc2_mask();
    logic [BANK_N-1:0] m = '0;
    for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction

  // Fast-interrupt index decode: bank 1, then bank 2, then basic
  function automatic logic fiq_pick(input logic [IDX_W-1:0] idx,
                                    input logic [BASIC_N-1:0] s0,
                                    input logic [BANK_N-1:0] s1,
                                    input logic [BANK_N-1:0] s2);
    if (idx < 7'd32)      return s1[idx[4:0]];
    else if (idx < 7'd64) return s2[idx[4:0]];
    else if (idx < 7'd72) return s0[idx[2:0]];
    else                  return 1'b0;
  endfunction
endpackage

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
  parameter int W = 32,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] SET_A = '0,
  parameter logic [ADDR_W-1:0] CLR_A = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      en,
  output logic [W-1:0]      pend
);
  logic set_hit, clr_hit;
  assign set_hit = wr && (addr == SET_A);
  assign clr_hit = wr && (addr == CLR_A);

  always_ff @(posedge clk) begin
    if (!rst_n)       en <= '0;
    else if (set_hit) en <= en | wdata;
    else if (clr_hit) en <= en & ~wdata;
  end

  assign pend = raw & en;

  assert_w1s_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> en == ($past(en) | $past(wdata)));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> en == ($past(en) & ~$past(wdata)));
  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(en));
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASIC_N-1:0] pend0,
  input  logic [BANK_N-1:0]  pend1,
  input  logic [BANK_N-1:0]  pend2,
  output logic [WORD_N-1:0]  word,
  output logic               irq
);
  localparam logic [BANK_N-1:0] M1 = sc1_mask();
  localparam logic [BANK_N-1:0] M2 = sc2_mask();

  logic cascade1, cascade2;
  assign cascade1 = |(pend1 & ~M1);
  assign cascade2 = |(pend2 & ~M2);

  assign word[BASIC_N-1:0] = pend0;
  assign word[SUM1_BIT]    = cascade1;
  assign word[SUM2_BIT]    = cascade2;

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign word[SC1_BASE+k] = pend1[sc1_src(k)];
  end
  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign word[SC2_BASE+k] = pend2[sc2_src(k)];
  end

  assign irq = |word;

  assert_sc_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend1 != '0) && ((pend1 & ~M1) == '0)) |-> !word[SUM1_BIT]);
  assert_sc_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend1[7] |-> word[SC1_BASE]);
  assert_sc_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend2[30] |-> word[WORD_N-1]);
endmodule

// File: rtl/irqc_fiq_sel.sv
module irqc_fiq_sel
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CTL_W-1:0]   wdata,
  input  logic [BASIC_N-1:0] s0,
  input  logic [BANK_N-1:0]  s1,
  input  logic [BANK_N-1:0]  s2,
  output logic [CTL_W-1:0]   ctl,
  output logic               fiq
);
  logic ctl_hit, sel_line;
  assign ctl_hit = wr && (addr == A_FCTL);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctl <= '0;
    else if (ctl_hit) ctl <= wdata;
  end

  assign sel_line = fiq_pick(ctl[IDX_W-1:0], s0, s1, s2);
  assign fiq      = ctl[CTL_W-1] & sel_line;

  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> ctl == $past(wdata));
  assert_fiq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[CTL_W-1] |-> !fiq);
  assert_fiq_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[IDX_W-1:0] > 7'd71) |-> !fiq);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [BASIC_N-1:0]  src_basic,
  input  logic [BANK_N-1:0]   src_bank1,
  input  logic [BANK_N-1:0]  src_bank2,
  output logic                irq_out,
  output logic                fiq_out
);
  logic [BASIC_N-1:0] en0, pend0;
  logic [BANK_N-1:0]  en1, pend1, en2, pend2;
  logic [WORD_N-1:0]  word;
  logic [CTL_W-1:0]   ctl;

  irqc_en_bank #(.W(BASIC_N), .ADDR_W(ADDR_W), .SET_A(A_SET0), .CLR_A(A_CLR0)) u_bank0 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[BASIC_N-1:0]), .raw(src_basic), .en(en0), .pend(pend0));
  irqc_en_bank #(.W(BANK_N), .ADDR_W(ADDR_W), .SET_A(A_SET1), .CLR_A(A_CLR1)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[BANK_N-1:0]), .raw(src_bank1), .en(en1), .pend(pend1));
  irqc_en_bank #(.W(BANK_N), .ADDR_W(ADDR_W), .SET_A(A_SET2), .CLR_A(A_CLR2)) u_bank2 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[BANK_N-1:0]), .raw(src_bank2), .en(en2), .pend(pend2));

  irqc_summary u_sum (
    .clk(clk), .rst_n(rst_n), .pend0(pend0), .pend1(pend1), .pend2(pend2),
    .word(word), .irq(irq_out));

  irqc_fiq_sel #(.ADDR_W(ADDR_W)) u_fiq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[CTL_W-1:0]), .s0(src_basic), .s1(src_bank1), .s2(src_bank2),
    .ctl(ctl), .fiq(fiq_out));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT0: bus_rdata[WORD_N-1:0]  = word;
      A_STAT1: bus_rdata[BANK_N-1:0]  = pend1;
      A_STAT2: bus_rdata[BANK_N-1:0]  = pend2;
      A_FCTL:  bus_rdata[CTL_W-1:0]   = ctl;
      A_SET1:  bus_rdata[BANK_N-1:0]  = en1;
      A_SET2:  bus_rdata[BANK_N-1:0]  = en2;
      A_SET0:  bus_rdata[BASIC_N-1:0] = en0;
      default: bus_rdata = '0;
    endcase
  end

  localparam logic [BANK_N-1:0] NS1 = ~sc1_mask();
  assert_cascade_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_bank1 & en1 & NS1) != '0) |-> irq_out);
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0]  src_basic = 0;
  logic [31:0] src_bank1 = 0, src_bank2 = 0;
  logic        irq_out, fiq_out;

  irqc_top dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
    .src_bank1(src_bank1), .src_bank2(src_bank2), .irq_out(irq_out), .fiq_out(fiq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int sc1[$] = '{7, 9, 10, 18, 19};
  int sc2[$] = '{21, 22, 23, 24, 25, 30};
  logic [7:0]  m_en0 = 0, m_fctl = 0;
  logic [31:0] m_en1 = 0, m_en2 = 0;
  int checks = 0, fails = 0;
  bit done = 0, run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en0 <= 0; m_en1 <= 0; m_en2 <= 0; m_fctl <= 0;
    end else if (bus_wr) begin
      case (bus_addr)
        6'h18: m_en0 <= m_en0 | bus_wdata[7:0];
        6'h24: m_en0 <= m_en0 & ~bus_wdata[7:0];
        6'h10: m_en1 <= m_en1 | bus_wdata;
        6'h1c: m_en1 <= m_en1 & ~bus_wdata;
        6'h14: m_en2 <= m_en2 | bus_wdata;
        6'h20: m_en2 <= m_en2 & ~bus_wdata;
        6'h0c: m_fctl <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w = 0;
    logic [31:0] p1 = src_bank1 & m_en1, p2 = src_bank2 & m_en2;
    w[7:0] = src_basic & m_en0;
    foreach (sc1[k]) begin w[10+k] = p1[sc1[k]]; p1[sc1[k]] = 0; end
    foreach (sc2[k]) begin w[15+k] = p2[sc2[k]]; p2[sc2[k]] = 0; end
    w[8] = (p1 != 0);
    w[9] = (p2 != 0);
    return w;
  endfunction

  function automatic logic exp_fiq();
    int idx = int'(m_fctl[6:0]);
    if (!m_fctl[7]) return 0;
    if (idx < 32) return src_bank1[idx];
    if (idx < 64) return src_bank2[idx-32];
    if (idx < 72) return src_basic[idx-64];
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return exp_word();
      6'h04: return src_bank1 & m_en1;
      6'h08: return src_bank2 & m_en2;
      6'h0c: return {24'h0, m_fctl};
      6'h10: return m_en1;
      6'h14: return m_en2;
      6'h18: return {24'h0, m_en0};
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(input logic [5:0] a);
    case (a)
      6'h00: return "R2 R3 R4 summary";
      6'h04, 6'h08: return "R1 bank status";
      6'h0c: return "R8 control";
      6'h10, 6'h14, 6'h18: return "R6 enable";
      default: return "R7 disable/unmapped";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R5 irq_out", {31'h0, irq_out}, {31'h0, |exp_word()});
      chk("R9 fiq_out", {31'h0, fiq_out}, {31'h0, exp_fiq()});
      chk(read_tag(bus_addr), bus_rdata, exp_read(bus_addr));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 0;
  endtask

  task automatic rd_expect(input string tag, input logic [5:0] a, input logic [31:0] e);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, e);
    #2;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    src_basic = 8'hff; src_bank1 = '1; src_bank2 = '1;
    step(3);
    rst_n = 1;
    step(1);
    // R10: reset state
    rd_expect("R10 basic enable", 6'h18, 0);
    rd_expect("R10 bank1 enable", 6'h10, 0);
    rd_expect("R10 bank2 enable", 6'h14, 0);
    rd_expect("R10 control", 6'h0c, 0);
    chk("R10 irq_out", {31'h0, irq_out}, 0);
    chk("R10 fiq_out", {31'h0, fiq_out}, 0);
    run = 1;
    src_basic = 0; src_bank1 = 0; src_bank2 = 0;
    // R6: basic enable keeps only low byte
    wr(6'h18, 32'hffff_ff0f);
    rd_expect("R6 basic mask low byte", 6'h18, 32'h0f);
    src_basic = 8'h12;
    rd_expect("R2 basic pending", 6'h00, 32'h02);
    wr(6'h24, 32'hff);
    src_basic = 0;
    // R3/R4: shortcut-only source in bank 1
    wr(6'h10, 32'hffff_ffff);
    src_bank1 = 32'h0000_0080;
    rd_expect("R3 R4 shortcut src7", 6'h00, 32'h0000_0400);
    src_bank1 = 32'h0000_0088;
    rd_expect("R3 cascade plus shortcut", 6'h00, 32'h0000_0500);
    // R5: basic disable cannot hide the cascade flag
    wr(6'h24, 32'hffff_ffff);
    chk("R5 unmaskable cascade", {31'h0, irq_out}, 1);
    // R4: bank-2 source 30 and 21
    wr(6'h14, 32'hffff_ffff);
    src_bank1 = 0; src_bank2 = 32'h4020_0000;
    rd_expect("R4 bank2 shortcuts", 6'h00, 32'h0010_8000);
    src_bank2 = 32'h0000_0001;
    rd_expect("R3 bank2 cascade", 6'h00, 32'h0000_0200);
    // R7: clear bank-2 source 0, reads of disable offsets give zero
    wr(6'h20, 32'h1);
    rd_expect("R7 cleared bank2 status", 6'h08, 0);
    rd_expect("R7 disable read", 6'h20, 0);
    chk("R7 irq after clear", {31'h0, irq_out}, 0);
    // R8/R9: selector ignores enable masks
    wr(6'h1c, 32'hffff_ffff);
    src_bank1 = 32'h20;
    wr(6'h0c, 32'h85);
    rd_expect("R8 control read", 6'h0c, 32'h85);
    chk("R9 bank1 index 5", {31'h0, fiq_out}, 1);
    src_bank2 = 32'h100; wr(6'h0c, 32'h80 | 40);
    chk("R9 bank2 index 40", {31'h0, fiq_out}, 1);
    src_basic = 8'h04; wr(6'h0c, 32'h80 | 66);
    chk("R9 basic index 66", {31'h0, fiq_out}, 1);
    src_basic = 8'hff; src_bank1 = '1; src_bank2 = '1;
    wr(6'h0c, 32'h80 | 100);
    chk("R9 index above 71", {31'h0, fiq_out}, 0);
    wr(6'h0c, 32'h05);
    chk("R9 selector disabled", {31'h0, fiq_out}, 0);
    // Mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      src_basic = 8'($urandom); src_bank1 = $urandom & $urandom; src_bank2 = $urandom & $urandom;
      if ($urandom_range(0, 2) == 0) begin
        logic [5:0] a = 6'($urandom_range(0, 9) * 4);
        wr(a, $urandom);
      end else begin
        bus_addr = 6'($urandom_range(0, 15) * 4);
        step(1);
      end
    end
    done = 1;
    report();
  end
endmodule